// File: doc/BRIEF.md
# Stereo Digital Volume with Soft Mute

This block scales a stereo stream of signed 24-bit PCM samples. Each channel has its own 8-bit attenuation code, which selects a gain in half-decibel steps from +24 dB down to -63.5 dB. A linear coefficient is formed from the code and multiplied into the sample. Results beyond full scale clip to the 24-bit limits.

A soft mute sits after the volume stage. It scales both channels by a raised-cosine gain that moves one table position for each accepted sample, so the signal fades out and back in without a click. Mute is requested by an external pin or by a control-register bit, and either one is enough. When the request drops in the middle of a fade, the fade turns around from the position it has reached. A status output shows when the sample on the outputs was produced at zero ramp gain.

The block sits between a sample source that strobes `in_valid` and a consumer that latches the outputs on `out_valid`.

Top module: `stereo_volume_softmute`

## Requirements
- R1: A sample accepted with `in_valid` high appears on the outputs with `out_valid` high exactly two clock cycles later. Between strobes, `out_valid` is low and the outputs hold their last value.
- R2: The code for each channel applies on its own. A code c (0 to 175) gives a coefficient floor(M(c mod 12) * 16 / 2^floor(c/12)), where M(k) = round(65536 * 10^(-k/40)). So code 0 gives x16, code 48 gives unity and code 60 gives one half. The volume result is floor(sample * coefficient / 65536).
- R3: A volume result above 8388607 gives 8388607. A result below -8388608 gives -8388608.
- R4: Every code above 175 acts exactly as code 175 (-63.5 dB).
- R5: Mute is requested when `mute_pin` or `mute_reg` is high. While it is requested, each accepted sample is scaled by G(p), where G(p) = round(32768 * (1 + cos(pi*p/16))) / 65536 and p is the ramp position (0 to 16). After that sample, p rises by one, stopping at 16. So the k-th sample of a mute from rest uses G(k), and G(8) is one half.
- R6: While mute is not requested, each accepted sample uses G(p) and then p falls by one, stopping at 0. A change of request mid-ramp continues from the current p, with no jump. Cycles without `in_valid` leave p unchanged.
- R7: `muted` is high exactly when the sample on the outputs was scaled by G(16), and both outputs are then zero.
- R8: While `rst_n` is low, `out_valid`, `muted` and both outputs are zero, and the ramp position returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe for both channels |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| vol_left | input | 8 | Left attenuation code, 0.5 dB per step |
| vol_right | input | 8 | Right attenuation code, 0.5 dB per step |
| mute_pin | input | 1 | Mute request from the device pin |
| mute_reg | input | 1 | Mute request from the control register bit |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| muted | output | 1 | Output sample was produced at zero ramp gain |

## Verification
The assertions assume that the source drives `in_valid` and the sample buses to known values from the first clock edge. The sign check also assumes that a sample is captured only on the cycle it is strobed. The bench meets both by driving every input on falling edges from time zero and by pulsing `in_valid` for a single cycle with idle cycles around it. No assertion depends on the pacing of mute requests. The bench still changes `mute_pin` and `mute_reg` only between samples, so each expected ramp position can be counted exactly from the number of strobes sent.

// File: rtl/svm_pkg.sv
package svm_pkg;
  localparam int SAMPLE_W    = 24;
  localparam int CODE_W      = 8;
  localparam int FRAC_W      = 16;
  localparam int MANT_W      = FRAC_W + 1;
  localparam int HEAD_OCT    = 4;
  localparam int VCOEF_W     = MANT_W + HEAD_OCT;
  localparam int STEPS_OCT   = 12;
  localparam int MAX_CODE    = 175;
  localparam int RAMP_STEPS  = 16;
  localparam int POS_W       = $clog2(RAMP_STEPS + 1);

  // 10^(-k/40) in unsigned Q1.16, one octave split into twelve half-dB steps
  function automatic logic [MANT_W-1:0] mant_of(input int k);
    case (k)
      0:       mant_of = 17'd65536;
      1:       mant_of = 17'd61870;
      2:       mant_of = 17'd58409;
      3:       mant_of = 17'd55142;
      4:       mant_of = 17'd52057;
      5:       mant_of = 17'd49145;
      6:       mant_of = 17'd46396;
      7:       mant_of = 17'd43801;
      8:       mant_of = 17'd41350;
      9:       mant_of = 17'd39037;
      10:      mant_of = 17'd36854;
      default: mant_of = 17'd34792;
    endcase
  endfunction

  // raised cosine 0.5*(1+cos(pi*p/16)) in unsigned Q1.16
  function automatic logic [MANT_W-1:0] ramp_gain(input int p);
    case (p)
      0:       ramp_gain = 17'd65536;
      1:       ramp_gain = 17'd64906;
      2:       ramp_gain = 17'd63042;
      3:       ramp_gain = 17'd60014;
      4:       ramp_gain = 17'd55938;
      5:       ramp_gain = 17'd50973;
      6:       ramp_gain = 17'd45308;
      7:       ramp_gain = 17'd39161;
      8:       ramp_gain = 17'd32768;
      9:       ramp_gain = 17'd26375;
      10:      ramp_gain = 17'd20228;
      11:      ramp_gain = 17'd14563;
      12:      ramp_gain = 17'd9598;
      13:      ramp_gain = 17'd5522;
      14:      ramp_gain = 17'd2494;
      15:      ramp_gain = 17'd630;
      default: ramp_gain = 17'd0;
    endcase
  endfunction
endpackage

// File: rtl/svm_gain_lut.sv
module svm_gain_lut
  import svm_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int OW = VCOEF_W
) (
  input  logic [CW-1:0] code,
  output logic [OW-1:0] coef
);
  localparam logic [CW-1:0] CODE_LIM = CW'(MAX_CODE);
  localparam logic [CW-1:0] OCT_DIV  = CW'(STEPS_OCT);

  logic [CW-1:0] code_eff;
  logic [CW-1:0] octave;
  logic [CW-1:0] step_in_oct;

  always_comb begin
    code_eff    = (code > CODE_LIM) ? CODE_LIM : code;
    octave      = code_eff / OCT_DIV;
    step_in_oct = code_eff % OCT_DIV;
    coef        = (OW'(mant_of(int'(step_in_oct))) << HEAD_OCT) >> octave;
  end
endmodule

// File: rtl/svm_scale_sat.sv
module svm_scale_sat #(
  parameter int SW = 24,
  parameter int CW = 21,
  parameter int FW = 16
) (
  input  logic signed [SW-1:0] smp,
  input  logic        [CW-1:0] coef,
  output logic signed [SW-1:0] res
);
  localparam int PW = SW + CW + 1;
  localparam logic signed [PW-1:0] POS_LIM = (PW'(1) <<< (SW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] NEG_LIM = -(PW'(1) <<< (SW - 1));

  logic signed [PW-1:0] smp_ext;
  logic signed [PW-1:0] coef_ext;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;

  always_comb begin
    smp_ext  = PW'(smp);
    coef_ext = PW'({1'b0, coef});
    prod     = smp_ext * coef_ext;
    scaled   = prod >>> FW;
    if (scaled > POS_LIM)      res = POS_LIM[SW-1:0];
    else if (scaled < NEG_LIM) res = NEG_LIM[SW-1:0];
    else                       res = scaled[SW-1:0];
  end
endmodule

// File: rtl/svm_mute_ramp.sv
module svm_mute_ramp
  import svm_pkg::*;
#(
  parameter int STEPS = RAMP_STEPS,
  parameter int PW    = POS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          req,
  output logic [PW-1:0] pos
);
  localparam logic [PW-1:0] FLOOR_POS = PW'(STEPS);

  logic [PW-1:0] pos_q, pos_d;
  logic          pos_en;

  always_comb begin
    pos_en = 1'b0;
    pos_d  = pos_q;
    if (step) begin
      if (req && (pos_q != FLOOR_POS)) begin
        pos_en = 1'b1;
        pos_d  = pos_q + PW'(1);
      end else if (!req && (pos_q != '0)) begin
        pos_en = 1'b1;
        pos_d  = pos_q - PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos = pos_q;

  // one table position per step, in either direction (R5, R6)
  assert_ramp_one_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + PW'(1)) ||
    (pos_q + PW'(1) == $past(pos_q)));
  // no movement without an accepted sample
  assert_ramp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos_q));
  // position never leaves the table
  assert_ramp_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= FLOOR_POS);
  // a request moves the ramp toward silence unless already there
  assert_ramp_direction_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && req && pos_q != FLOOR_POS) |=> (pos_q == $past(pos_q) + PW'(1)));
endmodule

// File: rtl/stereo_volume_softmute.sv
module stereo_volume_softmute
  import svm_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  input  logic        [CODE_W-1:0]   vol_left,
  input  logic        [CODE_W-1:0]   vol_right,
  input  logic                       mute_pin,
  input  logic                       mute_reg,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  output logic                       muted
);
  localparam int NCH = 2;
  localparam logic [POS_W-1:0] SILENT_POS = POS_W'(RAMP_STEPS);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic signed [SAMPLE_W-1:0] ch_in   [NCH];
  logic        [CODE_W-1:0]   ch_code [NCH];
  logic signed [SAMPLE_W-1:0] vol_res [NCH];
  logic signed [SAMPLE_W-1:0] s1_smp_q[NCH];
  logic signed [SAMPLE_W-1:0] mute_res[NCH];
  logic signed [SAMPLE_W-1:0] out_q   [NCH];

  assign ch_in[0]   = in_left;
  assign ch_in[1]   = in_right;
  assign ch_code[0] = vol_left;
  assign ch_code[1] = vol_right;

  logic             mute_req;
  logic [POS_W-1:0] ramp_pos;
  logic [POS_W-1:0] s1_pos_q;
  logic             s1_valid_q;
  logic [MANT_W-1:0] s1_gain;

  assign mute_req = mute_pin | mute_reg;

  svm_mute_ramp #(.STEPS(RAMP_STEPS), .PW(POS_W)) u_ramp (
    .clk   (clk),
    .rst_n (rst_i_n),
    .step  (in_valid),
    .req   (mute_req),
    .pos   (ramp_pos)
  );

  assign s1_gain = ramp_gain(int'(s1_pos_q));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [VCOEF_W-1:0] vcoef;

    svm_gain_lut #(.CW(CODE_W), .OW(VCOEF_W)) u_lut (
      .code (ch_code[ch]),
      .coef (vcoef)
    );

    svm_scale_sat #(.SW(SAMPLE_W), .CW(VCOEF_W), .FW(FRAC_W)) u_vol (
      .smp  (ch_in[ch]),
      .coef (vcoef),
      .res  (vol_res[ch])
    );

    svm_scale_sat #(.SW(SAMPLE_W), .CW(MANT_W), .FW(FRAC_W)) u_fade (
      .smp  (s1_smp_q[ch]),
      .coef (s1_gain),
      .res  (mute_res[ch])
    );

    // stage 1: volume-scaled sample
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n)      s1_smp_q[ch] <= '0;
      else if (in_valid) s1_smp_q[ch] <= vol_res[ch];
    end

    // stage 2: faded sample presented at the ports
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n)        out_q[ch] <= '0;
      else if (s1_valid_q) out_q[ch] <= mute_res[ch];
    end
  end

  logic out_valid_q;
  logic muted_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      s1_valid_q  <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      s1_valid_q  <= in_valid;
      out_valid_q <= s1_valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)      s1_pos_q <= '0;
    else if (in_valid) s1_pos_q <= ramp_pos;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)        muted_q <= 1'b0;
    else if (s1_valid_q) muted_q <= (s1_pos_q == SILENT_POS);
  end

  assign out_valid = out_valid_q;
  assign out_left  = out_q[0];
  assign out_right = out_q[1];
  assign muted     = muted_q;

  // two-stage strobe path
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    s1_valid_q |=> out_valid);
  // outputs frozen between strobes
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !s1_valid_q |=> ($stable(out_left) && $stable(out_right)));
  // volume never flips the sign of a sample
  assert_sign_kept_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    s1_valid_q |-> ((s1_smp_q[0] == '0) || (s1_smp_q[0][SAMPLE_W-1] == $past(in_left[SAMPLE_W-1]))));
  // zero-gain status agrees with the ports
  assert_muted_silent_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    muted |-> (out_left == '0 && out_right == '0));
endmodule

// File: tb/sim_stereo_volume_softmute.sv
module sim_stereo_volume_softmute;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [23:0] in_left = '0, in_right = '0;
  logic [7:0] vol_left = 8'd48, vol_right = 8'd48;
  logic mute_pin = 1'b0, mute_reg = 1'b0;
  logic out_valid, muted;
  logic signed [23:0] out_left, out_right;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  stereo_volume_softmute u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right),
    .vol_left(vol_left), .vol_right(vol_right),
    .mute_pin(mute_pin), .mute_reg(mute_reg),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .muted(muted)
  );

  // {left[63:40], right[39:16], vol_left[15:8], vol_right[7:0]}
  localparam int NV = 8;
  localparam logic [63:0] VEC [NV] = '{
    {24'h100000, 24'hF00000, 8'd48,  8'd48},
    {24'h000123, 24'h7FFFFF, 8'd0,   8'd60},
    {24'h100000, 24'hF00000, 8'd0,   8'd0},
    {24'h000001, 24'hFFFFFF, 8'd60,  8'd60},
    {24'h7FFFFF, 24'h800000, 8'd175, 8'd255},
    {24'h400000, 24'h400000, 8'd54,  8'd12},
    {24'h0ABCDE, 24'hF54321, 8'd30,  8'd100},
    {24'h7FFFFF, 24'h7FFFFF, 8'd200, 8'd175}
  };

  function automatic longint vol_coef(input int code);
    int c, k, n;
    longint m;
    c = (code > 175) ? 175 : code;
    k = c % 12;
    n = c / 12;
    m = longint'($rtoi(65536.0 * (10.0 ** (-k / 40.0)) + 0.5));
    return (m * 16) >>> n;
  endfunction

  function automatic longint clip24(input longint v);
    if (v > 64'sd8388607)  return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  function automatic longint vol_exp(input longint x, input int code);
    return clip24((x * vol_coef(code)) >>> 16);
  endfunction

  function automatic longint fade_gain(input int p);
    return longint'($rtoi(32768.0 * (1.0 + $cos(3.14159265358979 * p / 16.0)) + 0.5));
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // strobe one sample, then sample the ports after the two-stage latency
  task automatic send(input longint l, input longint r);
    @(negedge clk);
    in_left  = 24'(l);
    in_right = 24'(r);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "valid one cycle after strobe", longint'(out_valid), 0);
    @(negedge clk);
    chk("R1", "valid two cycles after strobe", longint'(out_valid), 1);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint el, er;
    string tag;
    repeat (3) @(negedge clk);
    chk("R8", "out_valid in reset", longint'(out_valid), 0);
    chk("R8", "muted in reset", longint'(muted), 0);
    chk("R8", "left in reset", longint'(out_left), 0);
    chk("R8", "right in reset", longint'(out_right), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table of volume vectors, mute inactive
    for (int i = 0; i < NV; i++) begin
      vol_left  = VEC[i][15:8];
      vol_right = VEC[i][7:0];
      send(longint'($signed(VEC[i][63:40])), longint'($signed(VEC[i][39:16])));
      el = vol_exp(longint'($signed(VEC[i][63:40])), int'(VEC[i][15:8]));
      er = vol_exp(longint'($signed(VEC[i][39:16])), int'(VEC[i][7:0]));
      tag = (VEC[i][15:8] > 8'd175 || VEC[i][7:0] > 8'd175) ? "R4" :
            ((el == 8388607 || el == -8388608 || er == 8388607 || er == -8388608) ? "R3" : "R2");
      chk(tag, $sformatf("vector %0d left", i), longint'(out_left), el);
      chk(tag, $sformatf("vector %0d right", i), longint'(out_right), er);
    end

    // R4: code above the limit equals the limit on the same sample
    chk("R4", "code 200 vs 175", longint'(out_left), longint'(out_right));

    // R1: outputs hold while no strobe
    el = longint'(out_left);
    repeat (5) @(negedge clk);
    chk("R1", "idle valid", longint'(out_valid), 0);
    chk("R1", "idle hold", longint'(out_left), el);

    // R5: fade out through the pin, unity volume, +/- 2^20
    vol_left  = 8'd48;
    vol_right = 8'd48;
    mute_pin  = 1'b1;
    for (int k = 0; k <= 18; k++) begin
      send(64'sd1048576, -64'sd1048576);
      if (k <= 16) begin
        chk("R5", $sformatf("fade-out step %0d left", k), longint'(out_left), (1048576 * fade_gain(k)) >>> 16);
        chk("R5", $sformatf("fade-out step %0d right", k), longint'(out_right), (-1048576 * fade_gain(k)) >>> 16);
      end else begin
        chk("R5", "stays silent", longint'(out_left), 0);
      end
      chk("R7", $sformatf("muted at step %0d", k), longint'(muted), (k >= 16) ? 1 : 0);
    end
    chk("R5", "half gain at step 8 table", fade_gain(8), 32768);

    // R6: fade back in
    mute_pin = 1'b0;
    for (int k = 0; k <= 17; k++) begin
      send(64'sd1048576, -64'sd1048576);
      el = (k <= 16) ? ((1048576 * fade_gain(16 - k)) >>> 16) : 64'sd1048576;
      chk("R6", $sformatf("fade-in step %0d left", k), longint'(out_left), el);
      chk("R7", $sformatf("muted fade-in %0d", k), longint'(muted), (k == 0) ? 1 : 0);
    end

    // R5/R6: register-bit request, then reversal mid-ramp with idle gaps
    mute_reg = 1'b1;
    for (int k = 0; k < 4; k++) begin
      send(64'sd1048576, 64'sd1048576);
      repeat (3) @(negedge clk);
    end
    chk("R5", "register request step 3", longint'(out_left), 16 * fade_gain(3));
    mute_reg = 1'b0;
    send(64'sd1048576, 64'sd1048576);
    chk("R6", "reversal continues at position 4", longint'(out_left), 16 * fade_gain(4));
    send(64'sd1048576, 64'sd1048576);
    chk("R6", "reversal next position 3", longint'(out_right), 16 * fade_gain(3));

    // R8: reset mid-fade returns to full gain
    mute_pin = 1'b1;
    send(64'sd1048576, 64'sd1048576);
    send(64'sd1048576, 64'sd1048576);
    mute_pin = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8", "outputs cleared by reset", longint'(out_left), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send(64'sd1048576, 64'sd1048576);
    chk("R8", "ramp at rest after reset", longint'(out_left), 64'sd1048576);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule